// File: doc/BRIEF.md
# Segment Limit Fault Checker

This block checks one memory access per strobe against a 32-bit segment limit and reports which fault class, if any, the access raises. The caller supplies the starting offset, the access size in bytes, whether the access goes through the stack segment or through a data/code segment, whether it is a stack pop, whether it is an instruction fetch, and the limit itself. The block forms the address of the last byte touched with one extra carry bit. Stack accesses report a stack fault, or a shutdown when the address wraps. Other accesses report a general-protection fault. For a pop it also returns the updated stack pointer.

Two cases depart from the plain limit test. A four-byte pop from the topmost aligned slot is always allowed, and the stack pointer rolls over to zero. A fetch under a full 4 GB limit follows a mode pin. In strict mode a multi-byte instruction starting at the last address faults. In relaxed mode no fetch under that limit faults.

The control path is a two-state machine. ST_IDLE moves to ST_REPORT on a strobe. ST_REPORT stays there on a further strobe and returns to ST_IDLE when there is none. Results appear in ST_REPORT, one cycle after the strobe.

Top module: `seg_limit_guard`

## Requirements
- R1: A strobe on `req_valid` in one cycle raises `rsp_valid` in the next cycle only. While `rsp_valid` is low, all three fault outputs are low.
- R2: A non-stack, non-fetch access faults on `gp_fault` exactly when its last-byte address, `offset + size - 1` formed in 33 bits, carries past bit 31 or exceeds the limit. A size of zero counts as one byte.
- R3: A stack access whose last-byte address exceeds the limit without carrying raises `stack_fault`.
- R4: A stack access whose last-byte address carries past bit 31 raises `shutdown` and not `stack_fault`.
- R5: A stack pop of size 4 at offset FFFFFFFCh raises no fault for any limit, and `next_sp` reads 0.
- R6: `next_sp` is `offset + size` modulo 2^32 for a stack pop. It is `offset` for every other access.
- R7: With `fetch_strict` high and limit FFFFFFFFh, a fetch of two or more bytes at FFFFFFFFh raises `gp_fault`. A one-byte fetch there does not.
- R8: With `fetch_strict` low and limit FFFFFFFFh, no fetch raises a fault, wrapping or not.
- R9: A fetch under any limit below FFFFFFFFh follows R2 in both modes.
- R10: At most one fault output is high. A stack access never raises `gp_fault`, and a non-stack access never raises `stack_fault` or `shutdown`. `req_is_fetch` is ignored for stack accesses.
- R11: After reset, `rsp_valid`, all fault outputs and `next_sp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe |
| req_offset | input | 32 | Starting offset within the segment |
| req_size | input | 4 | Access size in bytes (0 treated as 1) |
| req_is_stack | input | 1 | Access uses the stack segment |
| req_is_pop | input | 1 | Stack access is a pop |
| req_is_fetch | input | 1 | Access is an instruction fetch |
| req_limit | input | 32 | Segment limit (last valid offset) |
| fetch_strict | input | 1 | Strict fetch policy at a full 4 GB limit |
| rsp_valid | output | 1 | Result valid |
| gp_fault | output | 1 | General-protection fault |
| stack_fault | output | 1 | Stack fault |
| shutdown | output | 1 | Stack wrap shutdown |
| next_sp | output | 32 | Stack pointer after the access |

## Verification
The assertions check on every cycle that results follow strobes by one cycle and that fault outputs are quiet without a result. They also check that at most one fault is raised and that the fault goes to the channel matching the segment kind. The top-slot pop exemption and the relaxed full-limit fetch policy are checked on every cycle as well. Only the bench scenarios show the exact fault decision against the 33-bit last-byte test. That includes the strict-mode one-byte versus two-byte fetch, shutdown versus stack fault, and the wrapped `next_sp` values, which the bench compares against its own model over random and boundary accesses.

// File: rtl/seglim_pkg.sv
package seglim_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } seglim_state_e;

    typedef struct packed {
        logic gp;
        logic ss;
        logic sd;
    } seglim_fault_t;

endpackage

// File: rtl/seglim_span.sv
module seglim_span #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] limit,
    output logic              wrap,
    output logic              over
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SIZE_W-1:0] eff_size;
    logic [SUM_W-1:0]  last_byte;

    always_comb begin
        eff_size  = (size == '0) ? SIZE_W'(1) : size;
        last_byte = {1'b0, offset} + SUM_W'(eff_size) - SUM_W'(1);
        wrap      = last_byte[ADDR_W];
        over      = wrap | (last_byte[ADDR_W-1:0] > limit);
    end
endmodule

// File: rtl/seglim_classify.sv
module seglim_classify
    import seglim_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 4,
    parameter int POP_BYTES = 4
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] limit,
    input  logic              is_stack,
    input  logic              is_pop,
    input  logic              is_fetch,
    input  logic              strict,
    input  logic              wrap,
    input  logic              over,
    output seglim_fault_t     fault,
    output logic [ADDR_W-1:0] sp_after
);
    localparam logic [ADDR_W-1:0] TOP_SLOT = ADDR_W'(0) - ADDR_W'(POP_BYTES);

    logic              top_pop;
    logic              full_limit;
    logic [SIZE_W-1:0] eff_size;

    always_comb begin
        eff_size   = (size == '0) ? SIZE_W'(1) : size;
        full_limit = &limit;
        top_pop    = is_stack && is_pop && (size == SIZE_W'(POP_BYTES))
                     && (offset == TOP_SLOT);
        fault      = '0;
        if (is_stack) begin
            if (!top_pop) begin
                if (wrap) begin
                    fault.sd = 1'b1;
                end else if (over) begin
                    fault.ss = 1'b1;
                end
            end
        end else if (is_fetch && full_limit && !strict) begin
            fault = '0;
        end else begin
            fault.gp = over;
        end
        sp_after = (is_stack && is_pop) ? offset + ADDR_W'(eff_size) : offset;
    end
endmodule

// File: rtl/seg_limit_guard.sv
module seg_limit_guard
    import seglim_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 4,
    parameter int POP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_is_stack,
    input  logic              req_is_pop,
    input  logic              req_is_fetch,
    input  logic [ADDR_W-1:0] req_limit,
    input  logic              fetch_strict,
    output logic              rsp_valid,
    output logic              gp_fault,
    output logic              stack_fault,
    output logic              shutdown,
    output logic [ADDR_W-1:0] next_sp
);
    seglim_state_e     state_q, state_d;
    seglim_fault_t     fault_d, fault_q;
    logic [ADDR_W-1:0] sp_d, sp_q;
    logic              span_wrap, span_over;

    seglim_span #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_span (
        .offset (req_offset),
        .size   (req_size),
        .limit  (req_limit),
        .wrap   (span_wrap),
        .over   (span_over)
    );

    seglim_classify #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .POP_BYTES(POP_BYTES)) u_classify (
        .offset   (req_offset),
        .size     (req_size),
        .limit    (req_limit),
        .is_stack (req_is_stack),
        .is_pop   (req_is_pop),
        .is_fetch (req_is_fetch),
        .strict   (fetch_strict),
        .wrap     (span_wrap),
        .over     (span_over),
        .fault    (fault_d),
        .sp_after (sp_d)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_REPORT;
            ST_REPORT: if (!req_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= '0;
            sp_q    <= '0;
        end else if (req_valid) begin
            fault_q <= fault_d;
            sp_q    <= sp_d;
        end
    end

    always_comb begin
        rsp_valid   = 1'b0;
        gp_fault    = 1'b0;
        stack_fault = 1'b0;
        shutdown    = 1'b0;
        next_sp     = sp_q;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_REPORT: begin
                rsp_valid   = 1'b1;
                gp_fault    = fault_q.gp;
                stack_fault = fault_q.ss;
                shutdown    = fault_q.sd;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/seg_limit_guard_props.sv
module seg_limit_guard_props #(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 4,
    parameter int POP_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_offset,
    input logic [SIZE_W-1:0] req_size,
    input logic              req_is_stack,
    input logic              req_is_pop,
    input logic              req_is_fetch,
    input logic [ADDR_W-1:0] req_limit,
    input logic              fetch_strict,
    input logic              rsp_valid,
    input logic              gp_fault,
    input logic              stack_fault,
    input logic              shutdown,
    input logic [ADDR_W-1:0] next_sp
);
    localparam logic [ADDR_W-1:0] TOP_SLOT = ADDR_W'(0) - ADDR_W'(POP_BYTES);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(gp_fault || stack_fault || shutdown)); // R1
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gp_fault, stack_fault, shutdown}) <= 1); // R10
    AST_STACK_NO_GP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_stack) |=> !gp_fault); // R10
    AST_DATA_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_stack) |=> !(stack_fault || shutdown)); // R10
    AST_TOP_POP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_stack && req_is_pop && req_size == SIZE_W'(POP_BYTES)
         && req_offset == TOP_SLOT)
        |=> (next_sp == '0 && !stack_fault && !shutdown)); // R5
    AST_RELAXED_FULL_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_stack && req_is_fetch && !fetch_strict && (&req_limit))
        |=> !gp_fault); // R8
endmodule

bind seg_limit_guard seg_limit_guard_props #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .POP_BYTES(POP_BYTES)
) u_props (.*);

// File: tb/seg_limit_guard_bench.sv
module seg_limit_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_offset = '0;
    logic [3:0]  req_size = '0;
    logic        req_is_stack = 1'b0;
    logic        req_is_pop = 1'b0;
    logic        req_is_fetch = 1'b0;
    logic [31:0] req_limit = '0;
    logic        fetch_strict = 1'b0;
    logic        rsp_valid, gp_fault, stack_fault, shutdown;
    logic [31:0] next_sp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_limit_guard u_seg_limit_guard (
        .clk, .rst_n, .req_valid, .req_offset, .req_size, .req_is_stack,
        .req_is_pop, .req_is_fetch, .req_limit, .fetch_strict,
        .rsp_valid, .gp_fault, .stack_fault, .shutdown, .next_sp
    );

    // Expected {gp, ss, sd, next_sp} from the requirements
    function automatic logic [34:0] model(logic [31:0] off, logic [3:0] sz, logic stk,
                                          logic pop, logic fch, logic strict, logic [31:0] lim);
        longint unsigned eff  = (sz == 0) ? 1 : longint'(sz);
        longint unsigned last = longint'(off) + eff - 1;
        logic wrapd = last > 64'hFFFF_FFFF;
        logic ovr   = wrapd || (last[31:0] > lim);
        logic gp = 0, ss = 0, sd = 0;
        logic [31:0] sp = off;
        if (stk) begin
            if (pop) sp = off + 32'(eff);
            if (!(pop && sz == 4 && off == 32'hFFFF_FFFC)) begin
                if (wrapd) sd = 1; else if (ovr) ss = 1;
            end
        end else if (fch && lim == 32'hFFFF_FFFF) begin
            gp = strict ? wrapd : 1'b0;
        end else begin
            gp = ovr;
        end
        return {gp, ss, sd, sp};
    endfunction

    function automatic string tag_for(logic [31:0] off, logic [3:0] sz, logic stk,
                                      logic pop, logic fch, logic strict, logic [31:0] lim);
        longint unsigned eff = (sz == 0) ? 1 : longint'(sz);
        if (stk && pop && sz == 4 && off == 32'hFFFF_FFFC) return "R5";
        if (stk && (longint'(off) + eff - 1 > 64'hFFFF_FFFF)) return "R4";
        if (stk) return "R3";
        if (fch && lim == 32'hFFFF_FFFF) return strict ? "R7" : "R8";
        if (fch) return "R9";
        return "R2";
    endfunction

    task automatic chk(string req, logic [34:0] act, logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(logic [31:0] off, logic [3:0] sz, logic stk, logic pop,
                          logic fch, logic strict, logic [31:0] lim);
        logic [34:0] exp = model(off, sz, stk, pop, fch, strict, lim);
        string tg = tag_for(off, sz, stk, pop, fch, strict, lim);
        @(negedge clk);
        req_valid = 1; req_offset = off; req_size = sz; req_is_stack = stk;
        req_is_pop = pop; req_is_fetch = fch; fetch_strict = strict; req_limit = lim;
        @(negedge clk);
        req_valid = 0;
        chk("R1", 35'(rsp_valid), 35'd1);
        chk(tg, {gp_fault, stack_fault, shutdown, 32'd0}, {exp[34:32], 32'd0});
        chk("R6", 35'(next_sp), 35'(exp[31:0]));
        chk("R10", 35'($countones({gp_fault, stack_fault, shutdown}) <= 1), 35'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v = $urandom(32'd4242);
        seed_v = seed_v;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", {rsp_valid, gp_fault, stack_fault, shutdown, next_sp[30:0]}, 35'd0);
        chk("R11", 35'(next_sp[31]), 35'd0);
        rst_n = 1;
        @(negedge clk);
        // R2 data limit test
        access(32'h0000_1000, 4'd4, 0, 0, 0, 0, 32'h0000_1002);
        access(32'h0000_0FFC, 4'd4, 0, 0, 0, 0, 32'h0000_0FFF);
        access(32'h0000_2000, 4'd0, 0, 0, 0, 0, 32'h0000_2000);
        access(32'hFFFF_FFFF, 4'd2, 0, 0, 0, 0, 32'hFFFF_FFFF);
        // R3, R4 stack limit and wrap
        access(32'h0000_8000, 4'd4, 1, 0, 0, 0, 32'h0000_7FFF);
        access(32'hFFFF_FFFE, 4'd4, 1, 0, 0, 0, 32'hFFFF_FFFF);
        access(32'hFFFF_FFFE, 4'd4, 1, 1, 0, 0, 32'h0000_0010);
        // R5 top-slot pop, under full and small limit
        access(32'hFFFF_FFFC, 4'd4, 1, 1, 0, 0, 32'hFFFF_FFFF);
        access(32'hFFFF_FFFC, 4'd4, 1, 1, 0, 0, 32'h0000_1000);
        // R6 pop pointer update
        access(32'h0000_0100, 4'd2, 1, 1, 0, 0, 32'hFFFF_FFFF);
        // R7 strict fetch at full limit
        access(32'hFFFF_FFFF, 4'd2, 0, 0, 1, 1, 32'hFFFF_FFFF);
        access(32'hFFFF_FFFF, 4'd1, 0, 0, 1, 1, 32'hFFFF_FFFF);
        // R8 relaxed fetch at full limit
        access(32'hFFFF_FFFF, 4'd2, 0, 0, 1, 0, 32'hFFFF_FFFF);
        access(32'hFFFF_FFF0, 4'd15, 0, 0, 1, 0, 32'hFFFF_FFFF);
        // R9 fetch under a smaller limit
        access(32'h0000_1000, 4'd2, 0, 0, 1, 0, 32'h0000_1000);
        access(32'h0000_1000, 4'd1, 0, 0, 1, 1, 32'h0000_1000);
        // R10 fetch flag ignored on stack access
        access(32'hFFFF_FFFE, 4'd4, 1, 0, 1, 0, 32'hFFFF_FFFF);
        // R1 no strobe, no result
        @(negedge clk);
        chk("R1", {rsp_valid, gp_fault, stack_fault, shutdown}, 35'd0);
        // random mix biased to the top of the address space
        for (int i = 0; i < 400; i++) begin
            logic [31:0] off, lim;
            logic [3:0]  sz = 4'($urandom_range(0, 15));
            off = ($urandom_range(0, 1) == 1) ? (32'hFFFF_FFF0 | 32'($urandom_range(0, 15)))
                                              : $urandom;
            case ($urandom_range(0, 2))
                0:       lim = 32'hFFFF_FFFF;
                1:       lim = off + 32'($urandom_range(0, 8)) - 32'd4;
                default: lim = $urandom;
            endcase
            if ($urandom_range(0, 7) == 0) begin off = 32'hFFFF_FFFC; sz = 4'd4; end
            access(off, sz, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), lim);
        end
        @(negedge clk);
        chk("R1", {rsp_valid, gp_fault, stack_fault, shutdown}, 35'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule